// File: doc/BRIEF.md
# Synchronous Clock-Stop and Output Gating Controller

This block sits between the clock synthesiser and the output pads of a system clock generator. It takes the ungated source clocks (a CPU/memory clock, a PCI clock, a reference clock and a 48/24 MHz clock) and produces the gated output clocks. Every output has an enable bit from a control register bank. Outputs can also be stopped by group through two active-low stop requests, or all together through an active-low power-down input. A stopped output always rests LOW. A restarted output begins with a high phase of full width, so it never produces a short pulse.

Each stop or start passes through a fixed sequence. The request is first captured on a rising edge of the free-running PCI clock. It is then carried into the domain of the output by two flops, and the output's gate changes only on a falling edge of its own clock. A mode input sets the role of two shared pads. With mode high they drive the two highest-numbered memory clocks. With mode low they are the CPU-stop and PCI-stop request inputs. When every output has settled after power-down, the block raises a signal that tells the oscillator and the PLLs to shut off.

Top module: `ckgate_top`

## Requirements
- R1: A gated output rests LOW while stopped, and every high pulse it produces, including the first pulse after a restart and the last pulse before a stop, lasts exactly half a period of its source clock.
- R2: A stop request takes effect only after it has been captured on a rising edge of the PCI clock, then passed through two flops in the output's domain, and finally applied on a falling edge of the output's clock. An output therefore keeps toggling for at least two of its own periods after the request.
- R3: While the CPU-stop request is active (mode 0 and `shr_i[0]` = 0), the CPU and memory clocks stop LOW. The PCI, free-running PCI, reference and 48/24 MHz clocks keep running.
- R4: While the PCI-stop request is active (mode 0 and `shr_i[1]` = 0), the PCI clocks stop LOW. The CPU, memory, free-running PCI, reference and 48/24 MHz clocks keep running.
- R5: While `pd_n` = 0, every output stops LOW, including the free-running PCI clock. `pll_off` rises only after the free-running PCI output has stopped, and it falls when power returns.
- R6: With `mode` = 1, `shr_oe` = 2'b11, `shr_o` carries memory clocks 6 and 7, and `shr_i` has no effect. With `mode` = 0, `shr_oe` = 2'b00, `shr_o` = 2'b00, and `shr_i[0]` and `shr_i[1]` are the active-low CPU-stop and PCI-stop requests.
- R7: Each output has its own enable bit (1 = run, 0 = stop LOW). Clearing one bit stops only that output, and it stops through the same sequence as R2.
- R8: While `rst` is high, every output is LOW and `pll_off` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cpu | input | 1 | Ungated source clock for the CPU and memory outputs |
| clk_pci | input | 1 | Ungated source clock for the PCI outputs; also sequences all requests |
| clk_ref | input | 1 | Ungated reference source clock |
| clk_f48 | input | 1 | Ungated 48/24 MHz source clock |
| rst | input | 1 | Synchronous active-high reset, sampled in every clock domain |
| mode | input | 1 | 1: shared pads are memory clock outputs; 0: shared pads are stop inputs |
| pd_n | input | 1 | Active-low power-down request |
| shr_i | input | 2 | Shared pad inputs: [0] CPU-stop, [1] PCI-stop (active low, mode 0) |
| en_cpu | input | N_CPU | Per-output run enables, CPU clocks |
| en_sd | input | N_SD_DED+2 | Per-output run enables, memory clocks (top two feed the shared pads) |
| en_pci | input | N_PCI | Per-output run enables, PCI clocks |
| en_pcif | input | 1 | Run enable, free-running PCI clock |
| en_ref | input | N_REF | Per-output run enables, reference clocks |
| en_f48 | input | N_F48 | Per-output run enables, 48/24 MHz clocks |
| cpu_o | output | N_CPU | Gated CPU clocks |
| sd_o | output | N_SD_DED | Gated dedicated memory clocks |
| pci_o | output | N_PCI | Gated PCI clocks |
| pcif_o | output | 1 | Free-running PCI clock (stops only in power-down or by its enable) |
| ref_o | output | N_REF | Gated reference clocks |
| f48_o | output | N_F48 | Gated 48/24 MHz clocks |
| shr_o | output | 2 | Shared pad drive values (memory clocks 6 and 7 in mode 1) |
| shr_oe | output | 2 | Shared pad output enables |
| pll_off | output | 1 | Tells the oscillator and PLLs to shut off |

## Verification
The assertions check the following on every cycle: the shared pad direction and the quiet pads in each mode, the three-edge lag from the power-down and stop inputs to the run requests, and that `pll_off` is never high while the free-running PCI output can still pulse. Other behaviour involves several unrelated clocks and shows only in the bench scenarios. These cover which output groups keep toggling under each combination of stop, power-down and mode, the absence of short pulses across many stops and restarts, the pulses that still appear right after a stop request, and the way a single enable bit affects only its own output.

// File: rtl/ckgate_pkg.sv
`timescale 1ns/1ps
package ckgate_pkg;

  // Run qualifiers after they have been carried into the PCI domain.
  typedef struct packed {
    logic pwr_ok;   // power is up
    logic cpu_go;   // CPU and memory group may run
    logic pci_go;   // PCI group may run
  } gate_ctl_t;

  // A shared pad acts as a stop request only in mode 0; mode 1 always lets the group run.
  function automatic logic group_go(input logic mode_i, input logic pin_n);
    return mode_i | pin_n;
  endfunction

endpackage

// File: rtl/ckgate_sync.sv
`timescale 1ns/1ps
module ckgate_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/ckgate_cell.sv
`timescale 1ns/1ps
module ckgate_cell (
  input  logic clk,
  input  logic rst,
  input  logic req,
  output logic gclk
);
  logic req_s;
  logic run_q;

  // Two flops carry the request into this clock domain.
  ckgate_sync #(.W(1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (req),
    .q   (req_s)
  );

  // The gate changes only while the source is low, so the AND cannot chop a pulse.
  always_ff @(negedge clk) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= req_s;
  end

  assign gclk = clk & run_q;
endmodule

// File: rtl/ckgate_ctrl.sv
`timescale 1ns/1ps
module ckgate_ctrl
  import ckgate_pkg::*;
#(
  parameter int N_CPU = 4,
  parameter int N_SD  = 8,
  parameter int N_PCI = 6,
  parameter int N_REF = 3,
  parameter int N_F48 = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode,
  input  logic             pd_n,
  input  logic [1:0]       shr_i,
  input  logic [N_CPU-1:0] en_cpu,
  input  logic [N_SD-1:0]  en_sd,
  input  logic [N_PCI-1:0] en_pci,
  input  logic             en_pcif,
  input  logic [N_REF-1:0] en_ref,
  input  logic [N_F48-1:0] en_f48,
  output logic [N_CPU-1:0] req_cpu,
  output logic [N_SD-1:0]  req_sd,
  output logic [N_PCI-1:0] req_pci,
  output logic             req_pcif,
  output logic [N_REF-1:0] req_ref,
  output logic [N_F48-1:0] req_f48,
  output logic             pll_off
);
  localparam int W_CTL = $bits(gate_ctl_t);
  localparam int W_ALL = W_CTL + N_CPU + N_SD + N_PCI + 1 + N_REF + N_F48;
  // PCI edges to wait after the free request drops; covers 2 sync flops + the falling edge.
  localparam int W_CNT = 2;
  localparam logic [W_CNT-1:0] SETTLE = '1;

  gate_ctl_t        ctl_raw, ctl_q;
  logic [W_ALL-1:0] raw, syn;
  logic [N_CPU-1:0] en_cpu_q;
  logic [N_SD-1:0]  en_sd_q;
  logic [N_PCI-1:0] en_pci_q;
  logic             en_pcif_q;
  logic [N_REF-1:0] en_ref_q;
  logic [N_F48-1:0] en_f48_q;
  logic [W_CNT-1:0] settle_q;

  always_comb begin
    ctl_raw.pwr_ok = pd_n;
    ctl_raw.cpu_go = group_go(mode, shr_i[0]);
    ctl_raw.pci_go = group_go(mode, shr_i[1]);
  end

  assign raw = {ctl_raw, en_cpu, en_sd, en_pci, en_pcif, en_ref, en_f48};

  ckgate_sync #(.W(W_ALL)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw),
    .q   (syn)
  );

  assign {ctl_q, en_cpu_q, en_sd_q, en_pci_q, en_pcif_q, en_ref_q, en_f48_q} = syn;

  // Captured on the rising PCI edge, which is the first step of every stop/start.
  always_ff @(posedge clk) begin
    if (rst) begin
      req_cpu  <= '0;
      req_sd   <= '0;
      req_pci  <= '0;
      req_pcif <= 1'b0;
      req_ref  <= '0;
      req_f48  <= '0;
      settle_q <= '0;
      pll_off  <= 1'b0;
    end else begin
      req_cpu  <= en_cpu_q & {N_CPU{ctl_q.pwr_ok & ctl_q.cpu_go}};
      req_sd   <= en_sd_q  & {N_SD{ctl_q.pwr_ok & ctl_q.cpu_go}};
      req_pci  <= en_pci_q & {N_PCI{ctl_q.pwr_ok & ctl_q.pci_go}};
      req_pcif <= en_pcif_q & ctl_q.pwr_ok;
      req_ref  <= en_ref_q & {N_REF{ctl_q.pwr_ok}};
      req_f48  <= en_f48_q & {N_F48{ctl_q.pwr_ok}};
      if (ctl_q.pwr_ok || req_pcif) begin
        settle_q <= '0;
        pll_off  <= 1'b0;
      end else begin
        if (settle_q != SETTLE) settle_q <= settle_q + 1'b1;
        pll_off <= (settle_q == SETTLE);
      end
    end
  end
endmodule

// File: rtl/ckgate_top.sv
`timescale 1ns/1ps
module ckgate_top #(
  parameter int N_CPU    = 4,
  parameter int N_SD_DED = 6,
  parameter int N_PCI    = 6,
  parameter int N_REF    = 3,
  parameter int N_F48    = 2
) (
  input  logic                  clk_cpu,
  input  logic                  clk_pci,
  input  logic                  clk_ref,
  input  logic                  clk_f48,
  input  logic                  rst,
  input  logic                  mode,
  input  logic                  pd_n,
  input  logic [1:0]            shr_i,
  input  logic [N_CPU-1:0]      en_cpu,
  input  logic [N_SD_DED+1:0]   en_sd,
  input  logic [N_PCI-1:0]      en_pci,
  input  logic                  en_pcif,
  input  logic [N_REF-1:0]      en_ref,
  input  logic [N_F48-1:0]      en_f48,
  output logic [N_CPU-1:0]      cpu_o,
  output logic [N_SD_DED-1:0]   sd_o,
  output logic [N_PCI-1:0]      pci_o,
  output logic                  pcif_o,
  output logic [N_REF-1:0]      ref_o,
  output logic [N_F48-1:0]      f48_o,
  output logic [1:0]            shr_o,
  output logic [1:0]            shr_oe,
  output logic                  pll_off
);
  localparam int N_SD   = N_SD_DED + 2;
  localparam int O_SD   = N_CPU;
  localparam int O_PCI  = O_SD + N_SD;
  localparam int O_PCIF = O_PCI + N_PCI;
  localparam int O_REF  = O_PCIF + 1;
  localparam int O_F48  = O_REF + N_REF;
  localparam int N_ALL  = O_F48 + N_F48;

  logic [N_CPU-1:0] req_cpu;
  logic [N_SD-1:0]  req_sd;
  logic [N_PCI-1:0] req_pci;
  logic             req_pcif;
  logic [N_REF-1:0] req_ref;
  logic [N_F48-1:0] req_f48;
  logic [N_ALL-1:0] req_all, gclk_all;
  logic [1:0]       sd_shared;

  ckgate_ctrl #(
    .N_CPU (N_CPU), .N_SD (N_SD), .N_PCI (N_PCI), .N_REF (N_REF), .N_F48 (N_F48)
  ) u_ctrl (
    .clk      (clk_pci),
    .rst      (rst),
    .mode     (mode),
    .pd_n     (pd_n),
    .shr_i    (shr_i),
    .en_cpu   (en_cpu),
    .en_sd    (en_sd),
    .en_pci   (en_pci),
    .en_pcif  (en_pcif),
    .en_ref   (en_ref),
    .en_f48   (en_f48),
    .req_cpu  (req_cpu),
    .req_sd   (req_sd),
    .req_pci  (req_pci),
    .req_pcif (req_pcif),
    .req_ref  (req_ref),
    .req_f48  (req_f48),
    .pll_off  (pll_off)
  );

  assign req_all = {req_f48, req_ref, req_pcif, req_pci, req_sd, req_cpu};

  for (genvar i = 0; i < N_ALL; i++) begin : g_cell
    logic src;
    if (i < O_PCI) begin : g_cpu
      assign src = clk_cpu;
    end else if (i < O_REF) begin : g_pci
      assign src = clk_pci;
    end else if (i < O_F48) begin : g_ref
      assign src = clk_ref;
    end else begin : g_f48
      assign src = clk_f48;
    end
    ckgate_cell u_cell (
      .clk  (src),
      .rst  (rst),
      .req  (req_all[i]),
      .gclk (gclk_all[i])
    );
  end

  assign cpu_o     = gclk_all[0 +: N_CPU];
  assign sd_o      = gclk_all[O_SD +: N_SD_DED];
  assign sd_shared = gclk_all[O_SD + N_SD_DED +: 2];
  assign pci_o     = gclk_all[O_PCI +: N_PCI];
  assign pcif_o    = gclk_all[O_PCIF];
  assign ref_o     = gclk_all[O_REF +: N_REF];
  assign f48_o     = gclk_all[O_F48 +: N_F48];

  assign shr_oe = {2{mode}};
  assign shr_o  = mode ? sd_shared : 2'b00;
endmodule

// File: rtl/ckgate_chk.sv
`timescale 1ns/1ps
module ckgate_chk #(
  parameter int N_CPU = 4,
  parameter int N_SD  = 8,
  parameter int N_PCI = 6
) (
  input logic             clk_pci,
  input logic             rst,
  input logic             mode,
  input logic             pd_n,
  input logic [1:0]       shr_i,
  input logic [1:0]       shr_o,
  input logic [1:0]       shr_oe,
  input logic             pcif_o,
  input logic             pll_off,
  input logic [N_CPU-1:0] req_cpu,
  input logic [N_SD-1:0]  req_sd,
  input logic [N_PCI-1:0] req_pci
);
  // R6: pads drive in mode 1
  p_pads_drive_r6: assert property (@(posedge clk_pci) disable iff (rst)
    mode |-> (shr_oe == 2'b11));

  // R6: pads are quiet inputs in mode 0
  p_pads_quiet_r6: assert property (@(posedge clk_pci) disable iff (rst)
    !mode |-> (shr_oe == 2'b00 && shr_o == 2'b00));

  // R5: no run request unless power was up three PCI edges earlier
  p_pd_lag_r5: assert property (@(posedge clk_pci) disable iff (rst)
    (|{req_cpu, req_sd, req_pci}) |-> $past(pd_n, 3));

  // R3: CPU/memory requests need the CPU-stop pad released three edges earlier
  p_cpu_stop_lag_r3: assert property (@(posedge clk_pci) disable iff (rst)
    (|{req_cpu, req_sd}) |-> $past(mode | shr_i[0], 3));

  // R4: PCI requests need the PCI-stop pad released three edges earlier
  p_pci_stop_lag_r4: assert property (@(posedge clk_pci) disable iff (rst)
    (|req_pci) |-> $past(mode | shr_i[1], 3));

  // R5: shut-off is never signalled while the free PCI output can still pulse
  p_off_after_low_r5: assert property (@(negedge clk_pci) disable iff (rst)
    pll_off |-> !pcif_o);
endmodule

bind ckgate_top ckgate_chk #(
  .N_CPU (N_CPU), .N_SD (N_SD), .N_PCI (N_PCI)
) u_chk (
  .clk_pci (clk_pci),
  .rst     (rst),
  .mode    (mode),
  .pd_n    (pd_n),
  .shr_i   (shr_i),
  .shr_o   (shr_o),
  .shr_oe  (shr_oe),
  .pcif_o  (pcif_o),
  .pll_off (pll_off),
  .req_cpu (req_cpu),
  .req_sd  (req_sd),
  .req_pci (req_pci)
);

// File: tb/test_ckgate_top.sv
`timescale 1ns/1ps
module test_ckgate_top;
  localparam int N_CPU = 4, N_SD_DED = 6, N_PCI = 6, N_REF = 3, N_F48 = 2;
  localparam int N_SD = N_SD_DED + 2;

  logic clk_cpu = 0, clk_pci = 0, clk_ref = 0, clk_f48 = 0;
  logic rst, mode, pd_n;
  logic [1:0] shr_i;
  logic [N_CPU-1:0] en_cpu;
  logic [N_SD-1:0]  en_sd;
  logic [N_PCI-1:0] en_pci;
  logic             en_pcif;
  logic [N_REF-1:0] en_ref;
  logic [N_F48-1:0] en_f48;
  logic [N_CPU-1:0] cpu_o;
  logic [N_SD_DED-1:0] sd_o;
  logic [N_PCI-1:0] pci_o;
  logic pcif_o;
  logic [N_REF-1:0] ref_o;
  logic [N_F48-1:0] f48_o;
  logic [1:0] shr_o, shr_oe;
  logic pll_off;

  int errors = 0, checks = 0, runts = 0, rise_cnt = 0;
  bit done = 0;

  always #2.5 clk_cpu = ~clk_cpu;   // 200 MHz
  always #5   clk_pci = ~clk_pci;
  always #7   clk_ref = ~clk_ref;
  always #4   clk_f48 = ~clk_f48;

  ckgate_top #(
    .N_CPU(N_CPU), .N_SD_DED(N_SD_DED), .N_PCI(N_PCI), .N_REF(N_REF), .N_F48(N_F48)
  ) i_ckgate_top (
    .clk_cpu, .clk_pci, .clk_ref, .clk_f48, .rst, .mode, .pd_n, .shr_i,
    .en_cpu, .en_sd, .en_pci, .en_pcif, .en_ref, .en_f48,
    .cpu_o, .sd_o, .pci_o, .pcif_o, .ref_o, .f48_o, .shr_o, .shr_oe, .pll_off
  );

  // R1 monitors: every high pulse must be exactly half a source period
  real tr_c, tr_p, tr_r;
  bit  hr_c = 0, hr_p = 0, hr_r = 0;
  always @(posedge cpu_o[0]) begin tr_c = $realtime; hr_c = 1; rise_cnt++; end
  always @(negedge cpu_o[0]) if (hr_c && (($realtime - tr_c) < 2.49 || ($realtime - tr_c) > 2.51)) runts++;
  always @(posedge pci_o[0]) begin tr_p = $realtime; hr_p = 1; end
  always @(negedge pci_o[0]) if (hr_p && (($realtime - tr_p) < 4.99 || ($realtime - tr_p) > 5.01)) runts++;
  always @(posedge ref_o[0]) begin tr_r = $realtime; hr_r = 1; end
  always @(negedge ref_o[0]) if (hr_r && (($realtime - tr_r) < 6.99 || ($realtime - tr_r) > 7.01)) runts++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Seen-high masks, bit order {shr, f48, ref, pcif, pci, sd, cpu}
  task automatic observe(output logic [6:0] seen, output logic [N_CPU-1:0] cs,
                         output logic [N_REF-1:0] rs);
    seen = '0; cs = '0; rs = '0;
    for (int k = 0; k < 120; k++) begin
      #1;
      seen |= {|shr_o, |f48_o, |ref_o, pcif_o, |pci_o, |sd_o, |cpu_o};
      cs   |= cpu_o;
      rs   |= ref_o;
    end
  endtask

  // {mode, pd_n, shr_i[1:0], expected seen mask}
  localparam logic [10:0] VEC [7] = '{
    11'b1_1_00_1111111,   // R6: stop pads ignored in mode 1
    11'b0_1_11_0111111,   // R6: pads are inputs, released
    11'b0_1_10_0111100,   // R3: CPU stop
    11'b0_1_01_0111011,   // R4: PCI stop
    11'b0_1_00_0111000,   // R3/R4 together
    11'b1_0_11_0000000,   // R5: power-down
    11'b1_1_11_1111111    // R5: power restored
  };
  localparam string TAG [7] = '{"R6", "R6", "R3", "R4", "R3", "R5", "R5"};

  logic [6:0] seen;
  logic [N_CPU-1:0] cs;
  logic [N_REF-1:0] rs;

  initial begin
    rst = 1; mode = 1; pd_n = 1; shr_i = 2'b11;
    en_cpu = '1; en_sd = '1; en_pci = '1; en_pcif = 1; en_ref = '1; en_f48 = '1;
    #0.3;
    observe(seen, cs, rs);
    chk("R8 outputs low in reset", {25'd0, seen}, 32'd0);
    chk("R8 pll_off low in reset", {31'd0, pll_off}, 32'd0);
    chk("R6 pads drive in mode 1", {30'd0, shr_oe}, 32'd3);
    rst = 0;
    #300;

    for (int v = 0; v < 7; v++) begin
      {mode, pd_n, shr_i} = VEC[v][10:7];
      #300;
      observe(seen, cs, rs);
      chk({TAG[v], " group activity"}, {25'd0, seen}, {25'd0, VEC[v][6:0]});
      chk("R5 pll_off", {31'd0, pll_off}, {31'd0, ~VEC[v][9]});
      chk("R6 pad enables", {30'd0, shr_oe}, {30'd0, {2{VEC[v][10]}}});
    end

    // R7: single enable bits
    en_cpu = 4'b1101; en_ref = 3'b110;
    #300;
    observe(seen, cs, rs);
    chk("R7 cpu per-output", {28'd0, cs}, 32'hD);
    chk("R7 ref per-output", {29'd0, rs}, 32'h6);
    chk("R7 memory untouched", {31'd0, seen[1]}, 32'd1);
    en_cpu = '1; en_ref = '1;
    #300;

    // R2: outputs keep toggling for at least two periods after the request
    mode = 0; shr_i = 2'b11;
    #300;
    @(posedge clk_pci);
    #1.3;
    rise_cnt = 0;
    shr_i = 2'b10;
    #15;
    chk("R2 pulses after stop request", {31'd0, rise_cnt >= 2}, 32'd1);
    #300;
    rise_cnt = 0;
    #100;
    chk("R3 cpu stopped after sequence", rise_cnt, 32'd0);
    shr_i = 2'b11;
    #300;
    observe(seen, cs, rs);
    chk("R2 restart after release", {31'd0, seen[0]}, 32'd1);

    chk("R1 no short pulses", runts, 32'd0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #150000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule